// File: doc/BRIEF.md
# Bus-addressed twelve-channel code latch receiver

This block is a write-only slave on a two-wire I2C bus. It holds twelve 8-bit code latches, and each latch feeds one converter channel. A bus master sends a fixed three-byte write frame: a device address, then a channel selector, then the 8-bit code. When the data byte arrives complete, the code is stored in the selected latch and a one-cycle update strobe marks that channel.

SCL and SDA are brought into a system clock domain through two-flop synchronizers. The system clock must run at least eight times faster than SCL. START and STOP are found from SDA edges while SCL is high. The block acknowledges a byte by pulling SDA low through an open-drain enable output.

Three strap pins set the low three address bits, so eight of these receivers can share one bus. An asynchronous active-low reset clears every latch and returns the receiver to idle.

Top module: `i2c_chan_latch_slave`

## Requirements
- R1: While rst_n is low, every channel code is 0x00, no update strobe is high and sda_pull is 0. After a reset pulse in the middle of operation, all codes read 0x00.
- R2: The slave acknowledges an address byte only in one case: the byte's upper nibble, sent first, is 1001, its next three bits equal strap_sel[2:0], and its last bit (write = 0) is 0. To acknowledge, it holds sda_pull at 1 through the ninth SCL clock of that byte.
- R3: The slave gives no acknowledge when the address nibble or the strap bits differ, or when the last address bit is 1. For the rest of that frame it then never pulls SDA and changes no latch.
- R4: In the second byte, the upper nibble is ignored. A low nibble of n, for n from 1 to 12, selects channel n, which is bits [(n-1)*8 +: 8] of chan_code. The slave acknowledges the second and third bytes of a matched frame whatever the low nibble is.
- R5: The third byte is taken MSB first and becomes the selected channel's code. Low nibble values 0, 13, 14 and 15 change no latch.
- R6: Each write raises the strobe bit chan_upd[n-1] of that channel alone for exactly one system clock cycle, and it is raised in the same cycle that the channel's code changes. A code never changes without its strobe.
- R7: A STOP or a repeated START that comes before the third byte is complete leaves every latch unchanged. A repeated START begins a fresh frame.
- R8: Bytes after the third one in a frame are not acknowledged, and they cause no further latch writes.
- R9: sda_pull is 0 outside acknowledge bits. It never rises while SCL is high, and it is 0 once a frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_sel | input | 3 | Strap levels for the low three address bits |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| chan_code | output | 96 | Twelve 8-bit codes, channel n at bits [(n-1)*8 +: 8] |
| chan_upd | output | 12 | One-cycle update strobe per channel |

## Verification
The directed frames do three things. First, they write every channel from 1 to 12 with junk in the upper nibble of the selector, which separates correct channel decoding from an off-by-one or a full-byte compare. Second, they use the four unused selector codes, which must be acknowledged but must not write. Third, they present addresses that differ only in the fixed nibble, only in a strap bit, or only in the read/write bit, so each part of the address match is tested on its own. Aborted frames end with a STOP after the selector byte or with a repeated START in the middle of the data byte, and frames with a fourth byte separate a clean end of frame from a late or repeated write. Random frames with changing strap levels then mix all of these cases, and the latch contents and strobe counts are compared after every STOP.

// File: rtl/i2c_latch_pkg.sv
package i2c_latch_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 4;
    localparam logic [3:0]  DEV_ID = 4'b1001;

    typedef enum logic [1:0] {
        FR_ADDR,
        FR_SEL,
        FR_CODE,
        FR_EXTRA
    } frame_pos_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  scl_s, sda_s;

    assign scl_s = st_q.scl_pipe[STAGES-1];
    assign sda_s = st_q.sda_pipe[STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.scl_pipe = {st_q.scl_pipe[STAGES-2:0], scl_raw};
        st_d.sda_pipe = {st_q.sda_pipe[STAGES-2:0], sda_raw};
        st_d.scl_prev = scl_s;
        st_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_rise  = scl_s & ~st_q.scl_prev;
    assign scl_fall  = ~scl_s & st_q.scl_prev;
    assign start_det = scl_s & st_q.scl_prev & st_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & st_q.scl_prev & ~st_q.sda_prev & sda_s;
    assign sda_lvl   = sda_s;
endmodule

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx
    import i2c_latch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                sda_lvl,
    input  logic [2:0]          strap,
    output logic                ack_pull,
    output logic                wr_en,
    output logic [SEL_W-1:0]    wr_sel,
    output logic [BYTE_W-1:0]   wr_data
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic               active;
        frame_pos_e         pos;
        logic [CNT_W-1:0]   bitc;
        logic [BYTE_W-1:0]  shreg;
        logic               ack;
        logic [SEL_W-1:0]   sel;
        logic               wr;
        logic [BYTE_W-1:0]  wdata;
    } rx_t;

    rx_t rx_d, rx_q;
    logic addr_hit;

    assign addr_hit = (rx_q.shreg[7:4] == DEV_ID) &&
                      (rx_q.shreg[3:1] == strap) &&
                      !rx_q.shreg[0];

    always_comb begin
        rx_d    = rx_q;
        rx_d.wr = 1'b0;
        if (start_det) begin
            rx_d.active = 1'b1;
            rx_d.pos    = FR_ADDR;
            rx_d.bitc   = '0;
            rx_d.ack    = 1'b0;
        end else if (stop_det) begin
            rx_d.active = 1'b0;
            rx_d.bitc   = '0;
            rx_d.ack    = 1'b0;
        end else if (rx_q.active) begin
            if (scl_rise && (rx_q.bitc < CNT_W'(BYTE_W))) begin
                rx_d.shreg = {rx_q.shreg[BYTE_W-2:0], sda_lvl};
                rx_d.bitc  = rx_q.bitc + 1'b1;
            end else if (scl_fall) begin
                if (rx_q.ack) begin
                    rx_d.ack  = 1'b0;
                    rx_d.bitc = '0;
                    case (rx_q.pos)
                        FR_ADDR: rx_d.pos = FR_SEL;
                        FR_SEL:  rx_d.pos = FR_CODE;
                        default: rx_d.pos = FR_EXTRA;
                    endcase
                end else if (rx_q.bitc == CNT_W'(BYTE_W)) begin
                    case (rx_q.pos)
                        FR_ADDR: begin
                            if (addr_hit) rx_d.ack    = 1'b1;
                            else          rx_d.active = 1'b0;
                        end
                        FR_SEL: begin
                            rx_d.sel = rx_q.shreg[SEL_W-1:0];
                            rx_d.ack = 1'b1;
                        end
                        FR_CODE: begin
                            rx_d.ack   = 1'b1;
                            rx_d.wr    = 1'b1;
                            rx_d.wdata = rx_q.shreg;
                        end
                        default: rx_d.active = 1'b0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{active: 1'b0, pos: FR_ADDR, bitc: '0, shreg: '0,
                      ack: 1'b0, sel: '0, wr: 1'b0, wdata: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign ack_pull = rx_q.ack;
    assign wr_en    = rx_q.wr;
    assign wr_sel   = rx_q.sel;
    assign wr_data  = rx_q.wdata;
endmodule

// File: rtl/chan_latch_bank.sv
module chan_latch_bank #(
    parameter int unsigned NCH   = 12,
    parameter int unsigned DW    = 8,
    parameter int unsigned SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] lat_flat,
    output logic [NCH-1:0]    upd_stb
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_lat
        typedef struct packed {
            logic [DW-1:0] code;
            logic          stb;
        } lat_t;

        lat_t lt_d, lt_q;
        logic hit;

        assign hit = wr_en && (wr_sel == SEL_W'(ch + 1));

        always_comb begin
            lt_d     = lt_q;
            lt_d.stb = hit;
            if (hit) lt_d.code = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lt_q <= '{code: '0, stb: 1'b0};
            else        lt_q <= lt_d;
        end

        assign lat_flat[ch*DW +: DW] = lt_q.code;
        assign upd_stb[ch]           = lt_q.stb;
    end
endmodule

// File: rtl/i2c_chan_latch_slave.sv
module i2c_chan_latch_slave
    import i2c_latch_pkg::*;
#(
    parameter int unsigned NCH      = 12,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [2:0]            strap_sel,
    output logic                  sda_pull,
    output logic [NCH*BYTE_W-1:0] chan_code,
    output logic [NCH-1:0]        chan_upd
);
    logic              scl_rise, scl_fall, start_det, stop_det, sda_lvl;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    logic [BYTE_W-1:0] wr_data;

    i2c_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl)
    );

    i2c_frame_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .strap     (strap_sel),
        .ack_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    chan_latch_bank #(.NCH(NCH), .DW(BYTE_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .lat_flat (chan_code),
        .upd_stb  (chan_upd)
    );
endmodule

// File: rtl/i2c_chan_latch_chk.sv
module i2c_chan_latch_chk #(
    parameter int unsigned NCH = 12,
    parameter int unsigned DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_pull,
    input logic [NCH*DW-1:0] chan_code,
    input logic [NCH-1:0]    chan_upd
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (chan_code == '0 && chan_upd == '0 && !sda_pull))
        else $error("R1 reset state violated");

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_upd))
        else $error("R6 more than one strobe");

    assert_pull_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_in)
        else $error("R9 pull raised while SCL high");

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            chan_upd[ch] |=> !chan_upd[ch])
            else $error("R6 strobe longer than one cycle");

        assert_code_change_strobed_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(chan_code[ch*DW +: DW]) |-> chan_upd[ch])
            else $error("R6 code changed without strobe");
    end
endmodule

bind i2c_chan_latch_slave i2c_chan_latch_chk #(.NCH(NCH), .DW(i2c_latch_pkg::BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .chan_code (chan_code),
    .chan_upd  (chan_upd)
);

// File: tb/test_i2c_chan_latch_slave.sv
module test_i2c_chan_latch_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 12;
    localparam int Q = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scl_m = 1'b1;
    logic           sda_m = 1'b1;
    logic [2:0]     strap = 3'd5;
    logic           sda_pull;
    logic [NCH*8-1:0] chan_code;
    logic [NCH-1:0] chan_upd;
    logic           sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_chan_latch_slave #(.NCH(NCH)) i_i2c_chan_latch_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .strap_sel (strap),
        .sda_pull  (sda_pull),
        .chan_code (chan_code),
        .chan_upd  (chan_upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_code [NCH];
    int stb_cnt [NCH];
    int stb_ref [NCH];
    bit done = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) if (chan_upd[i]) stb_cnt[i] = stb_cnt[i] + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        sda_m = 1'b0; wclk(2*Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        sda_m = 1'b1; wclk(2*Q);
    endtask

    task automatic send_bit(input bit b, output bit seen);
        sda_m = b;    wclk(Q);
        scl_m = 1'b1; wclk(Q);
        seen = sda_bus;
        wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i], s);
        send_bit(1'b1, s);
        acked = !s;
    endtask

    function automatic bit addr_ok(input logic [7:0] a, input logic [2:0] s);
        return a[7:4] == 4'b1001 && a[3:1] == s && !a[0];
    endfunction

    function automatic logic [7:0] mk_addr(input logic [2:0] s, input bit rd);
        return {4'b1001, s, rd};
    endfunction

    task automatic snap();
        for (int i = 0; i < NCH; i++) stb_ref[i] = stb_cnt[i];
    endtask

    task automatic check_bank(input string req, input int wr_ch);
        for (int i = 0; i < NCH; i++) begin
            chk(chan_code[i*8 +: 8] == exp_code[i], req, chan_code[i*8 +: 8], exp_code[i]);
            chk((stb_cnt[i] - stb_ref[i]) == ((i == wr_ch) ? 1 : 0), {req, " strobe"},
                stb_cnt[i] - stb_ref[i], (i == wr_ch) ? 1 : 0);
        end
        chk(sda_pull == 1'b0, "R9 idle pull", sda_pull, 0);
    endtask

    // full frame with optional extra byte; checks acks and bank
    task automatic frame(input logic [7:0] a, input logic [7:0] sel, input logic [7:0] d,
                         input bit extra);
        bit ak;
        bit m;
        int ch;
        m = addr_ok(a, strap);
        ch = -1;
        if (m && sel[3:0] >= 4'd1 && sel[3:0] <= 4'd12) ch = int'(sel[3:0]) - 1;
        snap();
        bus_start();
        send_byte(a, ak);
        chk(ak == m, m ? "R2 address ack" : "R3 address nack", ak, m);
        send_byte(sel, ak);
        chk(ak == m, m ? "R4 selector ack" : "R3 selector no pull", ak, m);
        send_byte(d, ak);
        chk(ak == m, m ? "R5 code ack" : "R3 code no pull", ak, m);
        if (extra) begin
            send_byte(~d, ak);
            chk(ak == 1'b0, "R8 extra byte nack", ak, 0);
        end
        bus_stop();
        wclk(Q);
        if (ch >= 0) exp_code[ch] = d;
        check_bank(m ? (ch >= 0 ? "R5 write" : "R5 unused code") : "R3 ignored", ch);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit s;
        bit ak;
        for (int i = 0; i < NCH; i++) begin exp_code[i] = 8'h00; stb_cnt[i] = 0; end
        wclk(3);
        chk(chan_code == '0, "R1 reset codes", 0, 0);
        chk(sda_pull == 1'b0 && chan_upd == '0, "R1 reset pull/strobe", sda_pull, 0);
        rst_n = 1'b1;
        wclk(4);

        // R4 every channel with junk upper nibble
        for (int n = 1; n <= NCH; n++)
            frame(mk_addr(strap, 1'b0), {4'(n * 3 + 5), 4'(n)}, 8'(n * 19 + 7), 1'b0);
        // R5 unused selector codes
        frame(mk_addr(strap, 1'b0), 8'h00, 8'hAA, 1'b0);
        frame(mk_addr(strap, 1'b0), 8'h7D, 8'h55, 1'b0);
        frame(mk_addr(strap, 1'b0), 8'h3E, 8'h11, 1'b0);
        frame(mk_addr(strap, 1'b0), 8'hFF, 8'h22, 1'b0);
        // R3 mismatches
        frame({4'b1000, strap, 1'b0}, 8'h01, 8'hC3, 1'b0);
        frame(mk_addr(strap ^ 3'b010, 1'b0), 8'h02, 8'hC3, 1'b0);
        frame(mk_addr(strap, 1'b1), 8'h03, 8'hC3, 1'b0);
        // R8 extra byte
        frame(mk_addr(strap, 1'b0), 8'h04, 8'h9C, 1'b1);
        // R5 extreme codes
        frame(mk_addr(strap, 1'b0), 8'h0C, 8'hFF, 1'b0);
        frame(mk_addr(strap, 1'b0), 8'h01, 8'h00, 1'b0);

        // R7 STOP after selector
        snap();
        bus_start();
        send_byte(mk_addr(strap, 1'b0), ak);
        send_byte(8'h05, ak);
        bus_stop();
        wclk(Q);
        check_bank("R7 stop abort", -1);

        // R7 repeated START inside code byte, then new frame
        snap();
        bus_start();
        send_byte(mk_addr(strap, 1'b0), ak);
        send_byte(8'h06, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b1, s);
        bus_start();
        send_byte(mk_addr(strap, 1'b0), ak);
        chk(ak == 1'b1, "R7 restart address ack", ak, 1);
        send_byte(8'h07, ak);
        send_byte(8'h3C, ak);
        bus_stop();
        wclk(Q);
        exp_code[6] = 8'h3C;
        check_bank("R7 restart frame", 6);

        // random mix
        for (int k = 0; k < 110; k++) begin
            logic [7:0] a;
            logic [7:0] sl;
            logic [7:0] dd;
            int r;
            if (k % 10 == 0) strap = 3'($urandom);
            r = int'($urandom % 8);
            case (r)
                0: a = 8'($urandom);
                1: a = mk_addr(3'($urandom), 1'b0);
                2: a = mk_addr(strap, 1'b1);
                default: a = mk_addr(strap, 1'b0);
            endcase
            sl = 8'($urandom);
            dd = 8'($urandom);
            frame(a, sl, dd, ($urandom % 6) == 0);
        end

        // R1 asynchronous reset mid-run
        rst_n = 1'b0;
        wclk(2);
        chk(chan_code == '0, "R1 async clear", 0, 0);
        rst_n = 1'b1;
        wclk(4);
        for (int i = 0; i < NCH; i++) exp_code[i] = 8'h00;
        frame(mk_addr(strap, 1'b0), 8'h0B, 8'h5A, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial $urandom(32'd4711);
endmodule